// File: doc/BRIEF.md
# String-Repeat Iteration Controller

This block sequences a string instruction that carries a repeat prefix. A start strobe delivers the instruction context: the prefix kind, the address-size mode, whether the operation is a compare/scan, the current count register, the instruction start address and the instruction length. The controller then issues one execute request per iteration to an external string datapath. It waits for that datapath's completion handshake and decrements the count in the width the address size selects. It then decides whether the loop ends.

The loop can end in two ways. On a normal completion the controller pulses a done strobe and presents the address after the instruction. On an early exit, taken when an asynchronous event is pending between iterations of an unfinished loop, it pulses an interrupt strobe and a stop-trace strobe. It then presents the instruction's own start address, so the instruction restarts later with the partly decremented count it presents on its count output.

Encodings used on the ports: prefix 0 = none, 1 = plain repeat, 2 = repeat-while-equal, 3 = repeat-while-not-equal. Address size 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit.

Top module: `strrep_ctrl`

## Requirements
- R1: With prefix 0 the operation executes exactly once whatever the count. The count output is unchanged and the loop completes normally.
- R2: With any repeat prefix and a zero tested count, no execute request is issued. The loop completes normally and the count is unchanged.
- R3: In 16-bit mode only count bits [15:0] are tested and decremented. Bits above 15 keep their value.
- R4: In 32-bit mode only count bits [31:0] are tested. Each decrement writes back the 32-bit result zero-extended to the full count width.
- R5: In 64-bit mode all 64 count bits are tested and decremented.
- R6: After each iteration the loop ends when the decremented tested count is zero, so a count of N gives exactly N execute requests.
- R7: With prefix 2 and the compare input high, the loop also ends after an iteration whose zero flag, sampled with the handshake, is 0.
- R8: With prefix 3 and the compare input high, the loop also ends after an iteration whose zero flag is 1.
- R9: The zero flag has no effect when the compare input is low or the prefix is 1. Only the count ends such loops.
- R10: If the event input is high with the handshake of an iteration that does not end the loop, the controller exits early. The interrupt and stop-trace outputs pulse together, the address output equals the start address, and the count output holds the decremented count.
- R11: A pending event has no effect on an iteration that ends the loop. The exit is a normal completion.
- R12: Each execute request is high for exactly one cycle. No further request is issued until the completion handshake of the previous one.
- R13: Normal completion raises the done output for exactly one cycle, with the address output equal to start address plus instruction length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| prefix_i | input | 2 | Prefix kind (0 none, 1 repeat, 2 while-equal, 3 while-not-equal) |
| asize_i | input | 2 | Address-size mode (0 16-bit, 1 32-bit, 2/3 64-bit) |
| cmp_op_i | input | 1 | High for compare/scan operations |
| count_i | input | CW | Count register value at start |
| ip_i | input | AW | Start address of the instruction |
| ilen_i | input | LW | Instruction length in bytes |
| exec_done_i | input | 1 | Datapath completion handshake for the current iteration |
| zf_i | input | 1 | Zero flag produced by the iteration, valid with exec_done_i |
| event_i | input | 1 | Pending asynchronous event, sampled with exec_done_i |
| exec_req_o | output | 1 | Single-cycle execute request to the datapath |
| busy_o | output | 1 | High while an instruction is being sequenced |
| done_o | output | 1 | Normal completion pulse |
| intr_o | output | 1 | Early-exit pulse |
| stop_trace_o | output | 1 | Stop-trace pulse issued with an early exit |
| ip_o | output | AW | Next address: advanced on completion, start address on early exit |
| count_o | output | CW | Current count register value |

## Verification
The bench builds the controller with its default parameters: a 64-bit count, a 32-bit address and a 4-bit length. With a 64-bit count it can place nonzero bits above bit 15 and above bit 31. That shows that 16-bit mode preserves them, that 32-bit mode clears them on write-back, and that 64-bit mode tests them, all with counts small enough to keep loops short. A datapath stub in the bench answers each request with a handshake. It programs the zero flag and the event for a chosen iteration, which exercises each termination sense, the early exit and its restart.

// File: rtl/strrep_pkg.sv
package strrep_pkg;

    typedef enum logic [1:0] {
        PFX_NONE     = 2'd0,
        PFX_REP      = 2'd1,
        PFX_WHILE_EQ = 2'd2,
        PFX_WHILE_NE = 2'd3
    } pfx_e;

    typedef enum logic [1:0] {
        ASZ_16  = 2'd0,
        ASZ_32  = 2'd1,
        ASZ_64  = 2'd2,
        ASZ_64B = 2'd3
    } asz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        pfx_e pfx;
        asz_e asz;
        logic cmp;
    } ctx_t;

    localparam int NUM_MODES = 3;

    // width of the tested count slice for mode index 0/1/2
    function automatic int mode_width(input int idx);
        case (idx)
            0:       return 16;
            1:       return 32;
            default: return 64;
        endcase
    endfunction

    // whether a decrement clears bits above the tested slice
    function automatic bit mode_zext(input int idx);
        return (idx == 1);
    endfunction

    function automatic logic [1:0] mode_index(input asz_e a);
        case (a)
            ASZ_16:  return 2'd0;
            ASZ_32:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/strrep_count.sv
module strrep_count
    import strrep_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic [CW-1:0] cnt_i,
    input  asz_e          asz_i,
    output logic          is_zero_o,
    output logic          is_one_o,
    output logic [CW-1:0] next_o
);
    logic          zero_v [NUM_MODES];
    logic          one_v  [NUM_MODES];
    logic [CW-1:0] dec_v  [NUM_MODES];
    logic [1:0]    sel;

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int MW = (mode_width(g) < CW) ? mode_width(g) : CW;
        logic [MW-1:0] low;
        assign low       = cnt_i[MW-1:0];
        assign zero_v[g] = (low == '0);
        assign one_v[g]  = (low == MW'(1));
        if (MW == CW) begin : g_full
            assign dec_v[g] = cnt_i - CW'(1);
        end else if (mode_zext(g)) begin : g_zext
            assign dec_v[g] = {{(CW-MW){1'b0}}, low - MW'(1)};
        end else begin : g_keep
            assign dec_v[g] = {cnt_i[CW-1:MW], low - MW'(1)};
        end
    end

    assign sel       = mode_index(asz_i);
    assign is_zero_o = zero_v[sel];
    assign is_one_o  = one_v[sel];
    assign next_o    = dec_v[sel];

endmodule

// File: rtl/strrep_term.sv
module strrep_term
    import strrep_pkg::*;
(
    input  pfx_e pfx_i,
    input  logic cmp_i,
    input  logic zf_i,
    input  logic last_i,
    input  logic event_i,
    output logic finish_o,
    output logic abort_o
);
    logic zf_stop;

    always_comb begin
        zf_stop = 1'b0;
        if (cmp_i) begin
            case (pfx_i)
                PFX_WHILE_EQ: zf_stop = !zf_i;
                PFX_WHILE_NE: zf_stop = zf_i;
                default:      zf_stop = 1'b0;
            endcase
        end
    end

    assign finish_o = (pfx_i == PFX_NONE) || last_i || zf_stop;
    assign abort_o  = !finish_o && event_i;

endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
    import strrep_pkg::*;
#(
    parameter int CW = 64,
    parameter int AW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [1:0]    prefix_i,
    input  logic [1:0]    asize_i,
    input  logic          cmp_op_i,
    input  logic [CW-1:0] count_i,
    input  logic [AW-1:0] ip_i,
    input  logic [LW-1:0] ilen_i,
    input  logic          exec_done_i,
    input  logic          zf_i,
    input  logic          event_i,
    output logic          exec_req_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          intr_o,
    output logic          stop_trace_o,
    output logic [AW-1:0] ip_o,
    output logic [CW-1:0] count_o
);
    st_e           st;
    ctx_t          ctx;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] ip_q;
    logic [LW-1:0] len_q;

    logic          cur_zero;
    logic          cur_one;
    logic [CW-1:0] cnt_dec;
    logic          finish;
    logic          abort;
    logic          skip;
    logic [AW-1:0] ip_next;

    strrep_count #(.CW(CW)) u_count (
        .cnt_i     (cnt_q),
        .asz_i     (ctx.asz),
        .is_zero_o (cur_zero),
        .is_one_o  (cur_one),
        .next_o    (cnt_dec)
    );

    strrep_term u_term (
        .pfx_i    (ctx.pfx),
        .cmp_i    (ctx.cmp),
        .zf_i     (zf_i),
        .last_i   (cur_one),
        .event_i  (event_i),
        .finish_o (finish),
        .abort_o  (abort)
    );

    assign skip       = (ctx.pfx != PFX_NONE) && cur_zero;
    assign exec_req_o = (st == ST_ISSUE) && !skip;
    assign busy_o     = (st != ST_IDLE);
    assign count_o    = cnt_q;
    assign ip_next    = ip_q + AW'(len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            ctx          <= '0;
            cnt_q        <= '0;
            ip_q         <= '0;
            len_q        <= '0;
            done_o       <= 1'b0;
            intr_o       <= 1'b0;
            stop_trace_o <= 1'b0;
            ip_o         <= '0;
        end else begin
            done_o       <= 1'b0;
            intr_o       <= 1'b0;
            stop_trace_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        ctx   <= '{pfx: pfx_e'(prefix_i), asz: asz_e'(asize_i), cmp: cmp_op_i};
                        cnt_q <= count_i;
                        ip_q  <= ip_i;
                        len_q <= ilen_i;
                        st    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (skip) begin
                        done_o <= 1'b1;
                        ip_o   <= ip_next;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (exec_done_i) begin
                        if (ctx.pfx != PFX_NONE) begin
                            cnt_q <= cnt_dec;
                        end
                        if (finish) begin
                            done_o <= 1'b1;
                            ip_o   <= ip_next;
                            st     <= ST_IDLE;
                        end else if (abort) begin
                            intr_o       <= 1'b1;
                            stop_trace_o <= 1'b1;
                            ip_o         <= ip_q;
                            st           <= ST_IDLE;
                        end else begin
                            st <= ST_ISSUE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/strrep_chk.sv
module strrep_chk #(
    parameter int CW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          exec_req_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          intr_o,
    input logic          stop_trace_o,
    input logic [CW-1:0] count_o
);
    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        exec_req_o |=> !exec_req_o);

    // R12
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        exec_req_o |-> busy_o);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R10
    intr_trace_chk: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> stop_trace_o);

    // R10
    exit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && intr_o));

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(count_o));

endmodule

bind strrep_ctrl strrep_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .exec_req_o   (exec_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .intr_o       (intr_o),
    .stop_trace_o (stop_trace_o),
    .count_o      (count_o)
);

// File: tb/strrep_ctrl_bench.sv
`timescale 1ns/1ps
module strrep_ctrl_bench;
    localparam int CW = 64;
    localparam int AW = 32;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [1:0]    prefix_i = '0;
    logic [1:0]    asize_i = '0;
    logic          cmp_op_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic [AW-1:0] ip_i = '0;
    logic [LW-1:0] ilen_i = '0;
    logic          exec_done_i = 1'b0;
    logic          zf_i = 1'b0;
    logic          event_i = 1'b0;
    logic          exec_req_o, busy_o, done_o, intr_o, stop_trace_o;
    logic [AW-1:0] ip_o;
    logic [CW-1:0] count_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int            r_n;
    bit            r_done, r_intr, r_stop, r_pulse_bad, r_done_wide;
    logic [AW-1:0] r_ip;
    logic [CW-1:0] r_cnt;

    always #10 clk = ~clk;

    strrep_ctrl #(.CW(CW), .AW(AW), .LW(LW)) u_strrep_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .prefix_i(prefix_i),
        .asize_i(asize_i), .cmp_op_i(cmp_op_i), .count_i(count_i),
        .ip_i(ip_i), .ilen_i(ilen_i), .exec_done_i(exec_done_i),
        .zf_i(zf_i), .event_i(event_i), .exec_req_o(exec_req_o),
        .busy_o(busy_o), .done_o(done_o), .intr_o(intr_o),
        .stop_trace_o(stop_trace_o), .ip_o(ip_o), .count_o(count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one instruction; the stub answers each request one cycle later.
    // Iteration k (1-based) returns zf = zf_alt when k == zf_at, else zf_base;
    // event is high with the handshake of iteration ev_at (0 = never).
    task automatic run_op(input logic [1:0] pfx, input logic [1:0] asz, input logic cmp,
                          input logic [63:0] cnt, input logic [31:0] ip, input logic [3:0] len,
                          input logic zf_base, input int zf_at, input int ev_at);
        @(negedge clk);
        prefix_i = pfx; asize_i = asz; cmp_op_i = cmp;
        count_i = cnt; ip_i = ip; ilen_i = len; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        r_n = 0; r_done = 0; r_intr = 0; r_stop = 0; r_pulse_bad = 0; r_done_wide = 0;
        for (int guard = 0; guard < 4000; guard++) begin
            exec_done_i = 1'b0; event_i = 1'b0;
            if (done_o || intr_o) begin
                r_done = done_o; r_intr = intr_o; r_stop = stop_trace_o;
                r_ip = ip_o; r_cnt = count_o;
                break;
            end
            if (exec_req_o) begin
                r_n++;
                @(negedge clk);
                if (exec_req_o) r_pulse_bad = 1;
                exec_done_i = 1'b1;
                zf_i = (r_n == zf_at) ? !zf_base : zf_base;
                event_i = (r_n == ev_at);
            end
            @(negedge clk);
        end
        @(negedge clk);
        if (done_o) r_done_wide = 1;
    endtask

    task automatic t_reset();
        chk("R13 reset done", done_o, 0);
        chk("R12 reset req", exec_req_o, 0);
        chk("R10 reset intr", intr_o, 0);
        chk("R2 reset busy", busy_o, 0);
    endtask

    task automatic t_no_prefix();
        run_op(2'd0, 2'd2, 1'b1, 64'd5, 32'h1000, 4'd2, 1'b0, 0, 0);
        chk("R1 single exec", r_n, 1);
        chk("R1 count kept", r_cnt, 64'd5);
        chk("R13 done", r_done, 1);
        chk("R13 ip advanced", r_ip, 32'h1002);
        chk("R13 done one cycle", r_done_wide, 0);
        chk("R12 req one cycle", r_pulse_bad, 0);
    endtask

    task automatic t_zero_count();
        run_op(2'd1, 2'd0, 1'b0, 64'hABCD_0000, 32'h2000, 4'd1, 1'b0, 0, 0);
        chk("R2 no exec", r_n, 0);
        chk("R2 done", r_done, 1);
        chk("R2 count kept", r_cnt, 64'hABCD_0000);
        chk("R13 ip", r_ip, 32'h2001);
    endtask

    task automatic t_mode16();
        run_op(2'd1, 2'd0, 1'b0, 64'h1_0000_0003, 32'h3000, 4'd2, 1'b0, 0, 0);
        chk("R3 R6 exec count", r_n, 3);
        chk("R3 upper kept", r_cnt, 64'h1_0000_0000);
        chk("R12 req one cycle", r_pulse_bad, 0);
    endtask

    task automatic t_mode32_intr_restart();
        run_op(2'd1, 2'd1, 1'b0, 64'hFFFF_FFFF_0000_0003, 32'h4000, 4'd3, 1'b0, 0, 1);
        chk("R10 exec before exit", r_n, 1);
        chk("R10 intr", r_intr, 1);
        chk("R10 stop trace", r_stop, 1);
        chk("R10 ip rewound", r_ip, 32'h4000);
        chk("R4 zero-extended", r_cnt, 64'h2);
        run_op(2'd1, 2'd1, 1'b0, r_cnt, 32'h4000, 4'd3, 1'b0, 0, 0);
        chk("R10 restart execs", r_n, 2);
        chk("R10 restart done", r_done, 1);
        chk("R13 restart ip", r_ip, 32'h4003);
    endtask

    task automatic t_mode64();
        run_op(2'd1, 2'd2, 1'b0, 64'd4, 32'h5000, 4'd1, 1'b0, 0, 0);
        chk("R5 R6 exec count", r_n, 4);
        chk("R6 final count", r_cnt, 64'd0);
        run_op(2'd1, 2'd2, 1'b0, 64'h1_0000_0000, 32'h5100, 4'd1, 1'b0, 0, 1);
        chk("R5 upper tested exec", r_n, 1);
        chk("R5 full decrement", r_cnt, 64'hFFFF_FFFF);
        chk("R10 intr", r_intr, 1);
    endtask

    task automatic t_while_eq();
        run_op(2'd2, 2'd2, 1'b1, 64'd10, 32'h6000, 4'd2, 1'b1, 3, 0);
        chk("R7 stops on zf clear", r_n, 3);
        chk("R7 count", r_cnt, 64'd7);
        chk("R7 done", r_done, 1);
    endtask

    task automatic t_while_ne();
        run_op(2'd3, 2'd1, 1'b1, 64'd10, 32'h7000, 4'd2, 1'b0, 2, 0);
        chk("R8 stops on zf set", r_n, 2);
        chk("R8 count", r_cnt, 64'd8);
    endtask

    task automatic t_zf_ignored();
        run_op(2'd2, 2'd2, 1'b0, 64'd4, 32'h8000, 4'd1, 1'b0, 0, 0);
        chk("R9 non-compare ignores zf", r_n, 4);
        run_op(2'd1, 2'd2, 1'b1, 64'd3, 32'h8100, 4'd1, 1'b0, 2, 0);
        chk("R9 plain repeat ignores zf", r_n, 3);
        chk("R9 count", r_cnt, 64'd0);
    endtask

    task automatic t_event_last();
        run_op(2'd1, 2'd2, 1'b0, 64'd2, 32'h9000, 4'd4, 1'b0, 0, 2);
        chk("R11 execs", r_n, 2);
        chk("R11 done not intr", r_done, 1);
        chk("R11 no intr", r_intr, 0);
        chk("R11 ip advanced", r_ip, 32'h9004);
        run_op(2'd2, 2'd2, 1'b1, 64'd9, 32'h9100, 4'd1, 1'b1, 1, 1);
        chk("R11 zf end beats event", r_intr, 0);
        chk("R11 zf end execs", r_n, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_prefix();
        t_zero_count();
        t_mode16();
        t_mode32_intr_restart();
        t_mode64();
        t_while_eq();
        t_while_ne();
        t_zf_ignored();
        t_event_last();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule